// File: doc/BRIEF.md
# Paged Edge-Interrupt GPIO Controller

A 48-line general-purpose I/O block on a byte-wide read/write bus. The bus sees a 16-byte register window. The lines form six 8-bit ports. Each line has an output latch. A latch bit of 1 makes the pad pull the line low. A latch bit of 0 releases the line, so it can be read back as an input. A read of a port returns the pin levels after a two-flop synchroniser.

Only the lowest three ports can interrupt. Each of their lines has three bits: an enable bit, an edge-polarity bit and a captured-edge flag. These three sets of bits share one group of three addresses. A page register decides which set those addresses reach. A summary register shows which interrupt ports have at least one flag set. One level interrupt output stays high while any flag is set, so the line can be shared with other sources. Software clears a flag by writing its enable bit to 0 and then back to 1.

Top module: `pgpio_ctrl`

## Requirements
- R1: After reset, all output latches, enables, polarities and flags are 0. The page is the identification page (0xC0), `irq_out` is low and `pin_oe` is all zero.
- R2: A write to offset p (0..5) loads port p's latch, which appears on `pin_oe[8p+7:8p]` after that clock edge. A read of offset p returns the port's pin levels as they were two clock edges earlier.
- R3: A write to offset 7 of 0x80 selects the enable page, 0x40 the polarity page and 0xC0 the identification page. Any other value leaves the page unchanged. A read of offset 7 returns the current page code.
- R4: Offsets 8, 9 and 10 address interrupt ports 0, 1 and 2. On the enable page and the polarity page, a write stores the byte and a read returns the stored byte. On the identification page, a read returns the port's flags and a write has no effect.
- R5: A polarity bit of 1 captures rising edges and 0 captures falling edges. A flag is readable three clock edges after the pin changes.
- R6: A flag never sets while its enable bit is 0.
- R7: An enable bit of 0 clears its flag and holds it clear, so writing 0 and then 1 acknowledges the line. If a write of 0 to an enable bit falls in the same cycle as a qualifying edge on that line, the flag ends up clear.
- R8: A read of offset 6 returns, in bit k (k = 0..2), the OR of port k's flags. Bits 7:3 read as 0.
- R9: `irq_out` is high while any flag is set. It stays high until the last flag is cleared.
- R10: Edges on ports 3..5 never raise an interrupt. Reads of offsets 11..15 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 when `bus_rd` is low |
| pin_in | input | 48 | Sampled pad levels |
| pin_oe | output | 48 | 1 = pad pulls the line low, 0 = released |
| irq_out | output | 1 | Level interrupt request |

## Verification
Two actions can fall in the same cycle: an acknowledge write that clears an enable bit, and a qualifying edge arriving at that line's detector. The bench changes a pin and then times the disabling write so that it is sampled at the same edge where the flag would set. It then expects the flag to be clear and `irq_out` low. A cycle-level reference model in the bench, compared on every clock, also checks that the block arbitrates the same way in every other cycle.

// File: rtl/pgpio_pkg.sv
// Package: default sizes, derived counts and page codes for the paged GPIO block.
// Assumes byte-wide ports; page codes are 8-bit values written to the page register.
package pgpio_pkg;
    localparam int DEF_PORT_W    = 8;
    localparam int DEF_PORTS     = 6;
    localparam int DEF_IRQ_PORTS = 3;
    localparam int DEF_ADDR_W    = 4;
    localparam int DEF_LINES     = DEF_PORTS * DEF_PORT_W;
    localparam int DEF_IRQ_LINES = DEF_IRQ_PORTS * DEF_PORT_W;

    typedef enum logic [7:0] {
        PAGE_POL = 8'h40,
        PAGE_EN  = 8'h80,
        PAGE_ID  = 8'hC0
    } page_e;
endpackage

// File: rtl/pgpio_sync.sv
// Two-flop synchroniser across every pad input.
// Assumes pin_in is asynchronous to clk and only its level matters.
module pgpio_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two stages of resynchronisation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end

    assign lvl = sync_q;
endmodule

// File: rtl/pgpio_irq_port.sv
// One interrupt-capable port: enable, polarity and captured-edge flags.
// Assumes lvl is already synchronised; wr_en/wr_pol are single-cycle strobes
// already qualified by address and page.
module pgpio_irq_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_pol,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] en_o,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] en_q, pol_q, flag_q, prev_q;
    logic [W-1:0] en_next, hit, flag_next;

    // Next enable value: the written byte wins over the held one.
    always_comb en_next = wr_en ? wdata : en_q;

    // Edge qualification per line using the polarity selection.
    always_comb hit = (pol_q & lvl & ~prev_q) | (~pol_q & ~lvl & prev_q);

    // Capture qualified edges; a zero enable clears and holds the flag clear.
    always_comb flag_next = (flag_q | (en_q & hit)) & en_next;

    // State registers for this port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            flag_q <= '0;
            prev_q <= '0;
        end else begin
            en_q   <= en_next;
            flag_q <= flag_next;
            prev_q <= lvl;
            if (wr_pol) pol_q <= wdata;
        end
    end

    assign en_o   = en_q;
    assign pol_o  = pol_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/pgpio_ctrl.sv
// Paged GPIO controller top: output latches, page register, address decode,
// read multiplexer and interrupt summary.
// Assumes one bus access per cycle, PORT_W of 8 (the page code width) and
// IRQ_PORTS no larger than PORT_W.
module pgpio_ctrl
    import pgpio_pkg::*;
#(
    parameter int NUM_PORTS = DEF_PORTS,
    parameter int IRQ_PORTS = DEF_IRQ_PORTS,
    parameter int PORT_W    = DEF_PORT_W,
    parameter int ADDR_W    = DEF_ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [PORT_W-1:0]           bus_wdata,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
    output logic                        irq_out
);
    localparam int LINES     = NUM_PORTS * PORT_W;
    localparam int IRQ_LINES = IRQ_PORTS * PORT_W;
    localparam int OFF_PEND  = NUM_PORTS;
    localparam int OFF_PAGE  = NUM_PORTS + 1;
    localparam int OFF_IRQ0  = NUM_PORTS + 2;

    logic [LINES-1:0]     latch_q;
    logic [LINES-1:0]     lvl;
    page_e                page_q;
    logic [IRQ_LINES-1:0] irq_en, irq_pol, irq_flags;
    logic [IRQ_PORTS-1:0] pend;
    logic [PORT_W-1:0]    rd_val;

    pgpio_sync #(.W(LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .lvl    (lvl)
    );

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PORTS; gp++) begin : g_latch
            // Output latch of one port, loaded by a write to its data offset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    latch_q[gp*PORT_W +: PORT_W] <= '0;
                else if (bus_wr && bus_addr == ADDR_W'(gp))
                    latch_q[gp*PORT_W +: PORT_W] <= bus_wdata;
            end
        end

        for (gp = 0; gp < IRQ_PORTS; gp++) begin : g_irq
            logic sel;
            assign sel = bus_wr && (bus_addr == ADDR_W'(OFF_IRQ0 + gp));
            pgpio_irq_port #(.W(PORT_W)) u_port (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (sel && page_q == PAGE_EN),
                .wr_pol (sel && page_q == PAGE_POL),
                .wdata  (bus_wdata),
                .lvl    (lvl[gp*PORT_W +: PORT_W]),
                .en_o   (irq_en[gp*PORT_W +: PORT_W]),
                .pol_o  (irq_pol[gp*PORT_W +: PORT_W]),
                .flag_o (irq_flags[gp*PORT_W +: PORT_W])
            );
            assign pend[gp] = |irq_flags[gp*PORT_W +: PORT_W];
        end
    endgenerate

    // Page register: only the three defined codes are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= PAGE_ID;
        else if (bus_wr && bus_addr == ADDR_W'(OFF_PAGE) &&
                 (bus_wdata == PAGE_EN || bus_wdata == PAGE_POL || bus_wdata == PAGE_ID))
            page_q <= page_e'(bus_wdata);
    end

    // Read multiplexer over the whole window; unused offsets return zero.
    always_comb begin
        rd_val = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (bus_addr == ADDR_W'(p)) rd_val = lvl[p*PORT_W +: PORT_W];
        if (bus_addr == ADDR_W'(OFF_PEND)) rd_val = PORT_W'(pend);
        if (bus_addr == ADDR_W'(OFF_PAGE)) rd_val = PORT_W'(page_q);
        for (int p = 0; p < IRQ_PORTS; p++) begin
            if (bus_addr == ADDR_W'(OFF_IRQ0 + p)) begin
                case (page_q)
                    PAGE_EN:  rd_val = irq_en[p*PORT_W +: PORT_W];
                    PAGE_POL: rd_val = irq_pol[p*PORT_W +: PORT_W];
                    default:  rd_val = irq_flags[p*PORT_W +: PORT_W];
                endcase
            end
        end
    end

    assign bus_rdata = bus_rd ? rd_val : '0;
    assign pin_oe    = latch_q;
    assign irq_out   = |pend;
endmodule

// File: rtl/pgpio_ctrl_chk.sv
// Checker bound to pgpio_ctrl: temporal properties over its ports and the
// enable/flag state driven by the interrupt-port submodules.
module pgpio_ctrl_chk
    import pgpio_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic [DEF_ADDR_W-1:0]    bus_addr,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [DEF_PORT_W-1:0]    bus_rdata,
    input logic [DEF_LINES-1:0]     pin_oe,
    input logic                     irq_out,
    input logic [DEF_IRQ_LINES-1:0] irq_en,
    input logic [DEF_IRQ_LINES-1:0] irq_flags
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_out && pin_oe == '0));

    // R2
    latch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> ($past(bus_wr) && $past(bus_addr) < DEF_ADDR_W'(DEF_PORTS)));

    // R6
    set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_flags & ~$past(irq_flags)) & ~$past(irq_en)) == '0);

    // R7
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags & ~irq_en) == '0);

    // R8
    pend_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DEF_ADDR_W'(DEF_PORTS)) |-> bus_rdata[DEF_PORT_W-1:DEF_IRQ_PORTS] == '0);

    // R9
    irq_drop_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(bus_wr));

    // R10
    unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > DEF_ADDR_W'(DEF_PORTS + 1 + DEF_IRQ_PORTS)) |-> bus_rdata == '0);
endmodule

bind pgpio_ctrl pgpio_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out),
    .irq_en    (irq_en),
    .irq_flags (irq_flags)
);

// File: tb/pgpio_ctrl_tb.sv
// Bench for pgpio_ctrl: behavioural reference model checked every clock,
// plus directed register-level checks per requirement.
module pgpio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] ext = '1;
    logic [47:0] pin_in;
    logic [47:0] pin_oe;
    logic        irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    // Pads: external pull-up levels, pulled low wherever the block drives.
    assign pin_in = ext & ~pin_oe;

    pgpio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // Reference model state.
    logic [47:0] m_latch, m_s1, m_s2, m_prev;
    logic [23:0] m_en, m_pol, m_flag, m_nf, m_en_n;
    logic [7:0]  m_page;
    logic        m_hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_latch = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
            m_en = '0; m_pol = '0; m_flag = '0; m_page = 8'hC0;
        end else begin
            m_en_n = m_en;
            for (int i = 0; i < 24; i++) begin
                m_hit = m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
                m_nf[i] = m_flag[i] | (m_en[i] & m_hit);
            end
            if (bus_wr) begin
                if (bus_addr < 4'd6)
                    m_latch[int'(bus_addr)*8 +: 8] = bus_wdata;
                else if (bus_addr == 4'd7 &&
                         (bus_wdata == 8'h80 || bus_wdata == 8'h40 || bus_wdata == 8'hC0))
                    m_page = bus_wdata;
                else if (bus_addr >= 4'd8 && bus_addr <= 4'd10) begin
                    if (m_page == 8'h80) m_en_n[(int'(bus_addr) - 8)*8 +: 8] = bus_wdata;
                    else if (m_page == 8'h40) m_pol[(int'(bus_addr) - 8)*8 +: 8] = bus_wdata;
                end
            end
            m_flag = m_nf & m_en_n;
            m_en   = m_en_n;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_in;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Model comparison on every clock (R2 latch, R9 interrupt level).
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 model pin_oe", 64'(pin_oe), 64'(m_latch));
            chk("R9 model irq_out", 64'(irq_out), 64'(|m_flag));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<50000", cycles);
            finish_run();
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    logic [7:0] v;

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 irq_out", 64'(irq_out), 64'd0);
        chk("R1 pin_oe", 64'(pin_oe), 64'd0);
        rd(4'd7, v); chk("R1 R3 page after reset", 64'(v), 64'hC0);
        rd(4'd6, v); chk("R1 pending", 64'(v), 64'h00);

        // R2 latches drive pads low; reads give synchronised levels
        wr(4'd3, 8'h0F);
        wr(4'd4, 8'hA5);
        cyc(3);
        rd(4'd3, v); chk("R2 port3 read", 64'(v), 64'hF0);
        rd(4'd4, v); chk("R2 port4 read", 64'(v), 64'h5A);
        chk("R2 pin_oe", 64'(pin_oe), 64'h00A50F000000);

        // R3 R4 page selection and register readback
        wr(4'd7, 8'h40); wr(4'd8, 8'h01);
        wr(4'd7, 8'h80); wr(4'd8, 8'h03);
        wr(4'd7, 8'h55);
        rd(4'd7, v); chk("R3 bad code ignored", 64'(v), 64'h80);
        rd(4'd8, v); chk("R4 enable readback", 64'(v), 64'h03);
        wr(4'd7, 8'h40);
        rd(4'd8, v); chk("R4 polarity readback", 64'(v), 64'h01);

        // R5 wrong edge on line 0 (rising selected) is not captured
        ext[0] = 1'b0; cyc(4);
        chk("R5 falling ignored", 64'(irq_out), 64'd0);
        ext[0] = 1'b1; cyc(3);
        chk("R5 R9 rising captured", 64'(irq_out), 64'd1);
        wr(4'd7, 8'hC0);
        rd(4'd8, v); chk("R4 id read", 64'(v), 64'h01);
        rd(4'd6, v); chk("R8 pending port0", 64'(v), 64'h01);

        // R5 falling edge on line 1 (polarity 0)
        ext[1] = 1'b0; cyc(4);
        rd(4'd8, v); chk("R5 falling captured", 64'(v), 64'h03);

        // R7 R9 acknowledge one line at a time
        wr(4'd7, 8'h80); wr(4'd8, 8'h02); wr(4'd8, 8'h03);
        chk("R9 irq held", 64'(irq_out), 64'd1);
        wr(4'd7, 8'hC0);
        rd(4'd8, v); chk("R7 ack line0", 64'(v), 64'h02);
        wr(4'd7, 8'h80); wr(4'd8, 8'h01); wr(4'd8, 8'h03);
        chk("R9 irq released", 64'(irq_out), 64'd0);

        // R6 disabled line 2 does not capture
        ext[2] = 1'b0; cyc(4); ext[2] = 1'b1; cyc(4);
        chk("R6 disabled line", 64'(irq_out), 64'd0);

        // R10 ports 3..5 and unused offsets
        ext[30] = 1'b0; cyc(4); ext[30] = 1'b1; cyc(4);
        chk("R10 port3 edge", 64'(irq_out), 64'd0);
        wr(4'd12, 8'hFF); cyc(1);
        rd(4'd12, v); chk("R10 offset12 read", 64'(v), 64'h00);
        rd(4'd11, v); chk("R10 offset11 read", 64'(v), 64'h00);
        chk("R10 pin_oe unchanged", 64'(pin_oe), 64'h00A50F000000);

        // R4 writes on the identification page are ignored
        wr(4'd7, 8'hC0); wr(4'd8, 8'hFF);
        wr(4'd7, 8'h80);
        rd(4'd8, v); chk("R4 id write ignored", 64'(v), 64'h03);

        // R7 collision: disable write sampled at the edge where the flag would set
        wr(4'd7, 8'h40); wr(4'd10, 8'h01);
        wr(4'd7, 8'h80); wr(4'd10, 8'h01);
        ext[16] = 1'b0; cyc(4);
        ext[16] = 1'b1; cyc(2);
        wr(4'd10, 8'h00);
        chk("R7 collision irq", 64'(irq_out), 64'd0);
        wr(4'd10, 8'h01); cyc(2);
        chk("R7 collision stays clear", 64'(irq_out), 64'd0);

        // R8 R9 two ports pending together
        ext[16] = 1'b0; cyc(4); ext[16] = 1'b1; cyc(4);
        ext[0] = 1'b0; cyc(4); ext[0] = 1'b1; cyc(4);
        rd(4'd6, v); chk("R8 pending ports 0 and 2", 64'(v), 64'h05);
        wr(4'd10, 8'h00); wr(4'd10, 8'h01);
        chk("R9 irq with port0 left", 64'(irq_out), 64'd1);
        rd(4'd6, v); chk("R8 pending port0 only", 64'(v), 64'h01);
        wr(4'd8, 8'h02); wr(4'd8, 8'h03);
        chk("R9 irq all cleared", 64'(irq_out), 64'd0);

        cyc(2);
        finish_run();
    end
endmodule